// File: doc/BRIEF.md
# Sticky Device Status Register

This block holds an 8-bit device status word that gathers fault indications from several on-chip monitors. Four of its bits are sticky error flags. Each is raised by a single-cycle event pulse from its monitor and stays raised until it is consumed. A flag can be consumed in two ways. One is a read of the register by the host, which clears every sticky flag. The other is a data frame whose status field carried that flag, which clears only the flags that frame reported. One further bit is not sticky. It follows, one cycle late, a level that shows a user non-volatile write is in progress, and it drops by itself when that write ends.

The bit positions have fixed meanings. Bit 7 is a factory non-volatile array fault and bit 6 a user non-volatile array fault. Bit 5 is a user-register integrity mismatch, bit 4 the write-in-progress indication, and bit 2 an over- or under-temperature fault. Bits 3, 1 and 0 are unused. For the frame path, the host side pulses a capture strobe when it builds the frame's status field. The block then holds a snapshot of the register. When that frame has gone out, a sent strobe clears exactly the sticky bits present in the snapshot. A fault that arrives between capture and transmission is therefore kept.

Top module: `dev_status_reg`

## Requirements
- R1: After a synchronous active-low reset, `status` and `frame_status` are both 0x00.
- R2: A pulse on `ev_factory_nv`, `ev_user_nv` or `ev_temp` sets bit 7, 6 or 2 of `status` respectively at the next clock edge. The bit then stays 1 for as long as no clear occurs.
- R3: A pulse on `ev_integrity` sets bit 5 only while `init_done` is 1. When `init_done` is 0 the pulse has no effect on `status`.
- R4: Bits 3, 1 and 0 of `status` always read 0.
- R5: Bit 4 of `status` equals the value `nv_write_busy` had at the previous clock edge. It clears without any read.
- R6: In the cycle where `rd_strobe` is 1, `status` still shows the value before the clear. After that edge, bits 7, 6, 5 and 2 are 0 unless a new event arrives.
- R7: An event in the same cycle as `rd_strobe` leaves its bit set after the edge.
- R8: A `frame_capture` pulse copies the full `status` value into `frame_status` at that clock edge.
- R9: A `frame_sent` pulse clears only those sticky bits that are 1 in `frame_status`. Sticky bits that were set after the capture stay 1.
- R10: An event in the same cycle as a `frame_sent` that would clear its bit leaves that bit set.
- R11: Neither `rd_strobe` nor `frame_sent` changes bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_done | input | 1 | End-of-initialisation level; arms the integrity flag |
| ev_factory_nv | input | 1 | Factory non-volatile array fault pulse |
| ev_user_nv | input | 1 | User non-volatile array fault pulse |
| ev_integrity | input | 1 | User register integrity mismatch pulse |
| ev_temp | input | 1 | Temperature out-of-range pulse |
| nv_write_busy | input | 1 | Level, high while a user non-volatile write runs |
| rd_strobe | input | 1 | Host read of the status register |
| frame_capture | input | 1 | Status field of an outgoing frame is taken now |
| frame_sent | input | 1 | Frame carrying the captured status has been transmitted |
| status | output | 8 | Register value |
| frame_status | output | 8 | Snapshot placed in the outgoing frame |

## Verification
The assertions assume two things about the inputs. First, event inputs are single-cycle pulses that may coincide with any clear strobe. Second, `frame_sent` refers to the most recent snapshot, so the capture for a frame comes before its sent strobe. The stimulus therefore always pulses `frame_capture` on its own and issues `frame_sent` at least one cycle later. Deliberate collisions are limited to events against clears. The busy level is held for several cycles so that its one-cycle lag can be seen, and it is also left high across read and frame clears.

// File: rtl/dsr_pkg.sv
// Shared constants for the device status register.
// Assumes an 8-bit register; the bit positions are decoded by host software.
package dsr_pkg;
    localparam int REG_W   = 8;
    localparam int B_FAC   = 7;
    localparam int B_USR   = 6;
    localparam int B_INTEG = 5;
    localparam int B_BUSY  = 4;
    localparam int B_TEMP  = 2;
    localparam logic [REG_W-1:0] STICKY_MASK =
        REG_W'((1 << B_FAC) | (1 << B_USR) | (1 << B_INTEG) | (1 << B_TEMP));
endpackage

// File: rtl/dsr_event_gate.sv
// Maps the monitor event pulses onto register bit positions.
// The integrity event is qualified by the end-of-initialisation level.
// Assumes the events are single-cycle pulses from synchronous monitors.
module dsr_event_gate
    import dsr_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         init_done,
    input  logic         ev_factory_nv,
    input  logic         ev_user_nv,
    input  logic         ev_integrity,
    input  logic         ev_temp,
    output logic [W-1:0] set_vec
);
    // Build the per-bit set request vector
    always_comb begin
        set_vec          = '0;
        set_vec[B_FAC]   = ev_factory_nv;
        set_vec[B_USR]   = ev_user_nv;
        set_vec[B_INTEG] = ev_integrity & init_done;
        set_vec[B_TEMP]  = ev_temp;
    end
endmodule

// File: rtl/dsr_sticky_bit.sv
// One sticky flag: set by a request, held until a clear, set has priority.
// Assumes set and clr are synchronous to clk.
module dsr_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Latch the flag; a simultaneous set overrides the clear
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    // R7 / R10: a set request is never lost to a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    // R2: the flag holds while nothing clears it
    a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);
endmodule

// File: rtl/dsr_snapshot.sv
// Holds the status value placed into an outgoing frame.
// Assumes capture is pulsed once per frame, before the frame's sent strobe.
module dsr_snapshot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // Load the snapshot on capture, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (capture) dout <= din;
    end

    // R8: the snapshot equals the register value at the capture edge
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> dout == $past(din));
endmodule

// File: rtl/dev_status_reg.sv
// Device status register: sticky fault flags with read and frame clears,
// plus a live write-in-progress bit. Unused positions read 0.
// Assumes frame_sent refers to the latest frame_capture snapshot.
module dev_status_reg
    import dsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done,
    input  logic             ev_factory_nv,
    input  logic             ev_user_nv,
    input  logic             ev_integrity,
    input  logic             ev_temp,
    input  logic             nv_write_busy,
    input  logic             rd_strobe,
    input  logic             frame_capture,
    input  logic             frame_sent,
    output logic [REG_W-1:0] status,
    output logic [REG_W-1:0] frame_status
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] stat_q;

    dsr_event_gate #(.W(REG_W)) u_gate (
        .init_done     (init_done),
        .ev_factory_nv (ev_factory_nv),
        .ev_user_nv    (ev_user_nv),
        .ev_integrity  (ev_integrity),
        .ev_temp       (ev_temp),
        .set_vec       (set_vec)
    );

    dsr_snapshot #(.W(REG_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (frame_capture),
        .din     (stat_q),
        .dout    (frame_status)
    );

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (STICKY_MASK[i]) begin : g_sticky
            logic clr_i;
            // Clear on host read, or on a frame that reported this bit
            assign clr_i = rd_strobe | (frame_sent & frame_status[i]);
            dsr_sticky_bit u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (set_vec[i]),
                .clr   (clr_i),
                .q     (stat_q[i])
            );
        end else if (i == B_BUSY) begin : g_busy
            // Register the live write-in-progress level
            always_ff @(posedge clk) begin
                if (!rst_n) stat_q[i] <= 1'b0;
                else        stat_q[i] <= nv_write_busy;
            end
        end else begin : g_rsvd
            assign stat_q[i] = 1'b0;
        end
    end

    assign status = stat_q;

    // R5 / R11: the busy bit tracks the level regardless of clears
    a_r5_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status[B_BUSY] == $past(nv_write_busy));
    // R3: no integrity flag appears while initialisation is open
    a_r3_integ_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !status[B_INTEG]) |=> !status[B_INTEG]);
    // R6: a read with no new events empties all sticky flags
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !ev_factory_nv && !ev_user_nv && !ev_integrity && !ev_temp)
        |=> (status & STICKY_MASK) == '0);
    // R9: a frame clear never sets a bit and keeps unreported bits
    a_r9_frame_scope: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sent && !rd_strobe) |=>
        ((($past(status) & ~$past(frame_status)) & STICKY_MASK) & ~status) == '0);
endmodule

// File: tb/dev_status_reg_test.sv
module dev_status_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_done = 1'b0;
    logic       ev_factory_nv = 1'b0, ev_user_nv = 1'b0;
    logic       ev_integrity = 1'b0, ev_temp = 1'b0;
    logic       nv_write_busy = 1'b0, rd_strobe = 1'b0;
    logic       frame_capture = 1'b0, frame_sent = 1'b0;
    logic [7:0] status, frame_status;
    int         n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    dev_status_reg uut (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        {ev_factory_nv, ev_user_nv, ev_integrity, ev_temp} = '0;
        {rd_strobe, frame_capture, frame_sent} = '0;
    endtask

    task automatic flush();
        idle(); rd_strobe = 1'b1; step(); idle();
    endtask

    task automatic t_reset();
        chk("R1 status", status, 8'h00);
        chk("R1 frame_status", frame_status, 8'h00);
    endtask

    task automatic t_set_hold();
        flush();
        ev_temp = 1'b1; step(); idle();
        chk("R2 temp set", status, 8'h04);
        step(); step(); step();
        chk("R2 temp held", status, 8'h04);
        ev_factory_nv = 1'b1; ev_user_nv = 1'b1; step(); idle();
        chk("R2 fac/usr set", status, 8'hC4);
    endtask

    task automatic t_read_clear();
        rd_strobe = 1'b1;
        chk("R6 pre-clear value", status, 8'hC4);
        step(); idle();
        chk("R6 cleared", status, 8'h00);
    endtask

    task automatic t_integrity();
        flush();
        init_done = 1'b0; ev_integrity = 1'b1; step(); idle();
        chk("R3 ignored before init", status, 8'h00);
        init_done = 1'b1; ev_integrity = 1'b1; step(); idle();
        chk("R3 set after init", status, 8'h20);
    endtask

    task automatic t_reserved();
        flush();
        nv_write_busy = 1'b1;
        {ev_factory_nv, ev_user_nv, ev_integrity, ev_temp} = '1;
        step(); idle();
        chk("R4 reserved zero", status & 8'h0B, 8'h00);
        chk("R4 full value", status, 8'hF4);
        nv_write_busy = 1'b0; step();
    endtask

    task automatic t_busy();
        flush();
        nv_write_busy = 1'b1;
        chk("R5 lag one cycle", status, 8'h00);
        step();
        chk("R5 busy shown", status, 8'h10);
        rd_strobe = 1'b1; step(); idle();
        chk("R11 read keeps busy", status, 8'h10);
        frame_capture = 1'b1; step(); idle();
        frame_sent = 1'b1; step(); idle();
        chk("R11 frame keeps busy", status, 8'h10);
        nv_write_busy = 1'b0; step();
        chk("R5 self clear", status, 8'h00);
    endtask

    task automatic t_read_collide();
        flush();
        ev_temp = 1'b1; step(); idle();
        rd_strobe = 1'b1; ev_factory_nv = 1'b1; step(); idle();
        chk("R7 set beats read", status, 8'h80);
    endtask

    task automatic t_frame();
        flush();
        ev_factory_nv = 1'b1; ev_temp = 1'b1; step(); idle();
        frame_capture = 1'b1; step(); idle();
        chk("R8 snapshot", frame_status, 8'h84);
        ev_user_nv = 1'b1; step(); idle();
        chk("R9 pre-send", status, 8'hC4);
        frame_sent = 1'b1; step(); idle();
        chk("R9 only reported cleared", status, 8'h40);
    endtask

    task automatic t_frame_collide();
        flush();
        ev_temp = 1'b1; step(); idle();
        frame_capture = 1'b1; step(); idle();
        frame_sent = 1'b1; ev_temp = 1'b1; step(); idle();
        chk("R10 set beats frame", status, 8'h04);
        frame_sent = 1'b1; step(); idle();
        chk("R10 later frame clears", status, 8'h00);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                step();
                t_reset();
                t_set_hold();
                t_read_clear();
                t_integrity();
                t_reserved();
                t_busy();
                t_read_collide();
                t_frame();
                t_frame_collide();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule